// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This unit sits between the receive and transmit halves of a FIFO-based UART and handles both hardware (RTS/CTS) and software (XON/XOFF) flow control with no processor involvement. On the receive side it compares the RX FIFO fill level against a high and a low threshold. From that comparison it drives the active-low RTS output with hysteresis, and it asks the transmitter to insert an XOFF or XON sequence. It also inspects every received byte. Bytes that form a configured flow-control sequence pause or resume the local transmitter and are removed from the data path. All other bytes are forwarded for writing into the RX FIFO.

On the transmit side it produces a single permission signal that the transmitter samples before it starts each new FIFO character. A character already being shifted out is not affected. Permission is withdrawn while a synchronized CTS is deasserted, while a received XOFF is in force, or while a control sequence is waiting to be sent. Control characters are offered one at a time with a request and acknowledge pair. Hardware RTS, hardware CTS and software flow control each have their own enable and do not depend on each other or on any interrupt setting. Baud generation, serializers and register access live elsewhere.

Top module: `uart_autoflow`

## Requirements
- R1: After reset rts_n is low, tx_data_ok is high, tx_ctrl_req is low and rx_push is low.
- R2: With rts_auto_en high and rs485_en low, rts_n goes high one clock after rx_level is sampled at or above hi_thresh. It stays high while the level lies between the thresholds. It returns low one clock after rx_level is sampled at or below lo_thresh.
- R3: With rts_auto_en low and rs485_en low, rts_n stays low whatever the FIFO level.
- R4: With rs485_en high, rts_n equals the inverse of rs485_dir, whatever the automatic RTS state.
- R5: With cts_auto_en high, a high level on cts_n clears tx_data_ok after exactly CTS_SYNC clocks (default 2), and a low level restores it after the same delay. With cts_auto_en low, cts_n has no effect. This holds whatever rts_auto_en is.
- R6: In single-character mode (two_char_en low, sw_rx_en high), a received byte equal to xoff_char1 clears tx_data_ok and a byte equal to xon_char1 restores it. Neither byte is forwarded on rx_push.
- R7: In two-character mode, the transmitter is paused only by xoff_char1 directly followed by xoff_char2, and resumed only by xon_char1 directly followed by xon_char2. A lone first character changes nothing, and the bytes of a matched pair are not forwarded.
- R8: In two-character mode, a first character followed by a byte that does not complete the pair forwards both bytes in arrival order and leaves the pause state unchanged. The second byte is matched again as a possible first character.
- R9: Every byte that is not consumed appears on rx_push_data with rx_push high for one clock, one clock after its rx_valid (two clocks for a byte replayed after a broken pair). With sw_rx_en low, every byte is forwarded and no pause is applied.
- R10: With sw_tx_en high, the clock in which rx_level is first sampled at or above hi_thresh raises tx_ctrl_req one clock later with tx_ctrl_char = xoff_char1. Sampling at or below lo_thresh does the same with xon_char1. In two-character mode the second character of the pair follows after the first acknowledge. The request drops after the final acknowledge, and each character is held until it is acknowledged.
- R11: While tx_ctrl_req is high, tx_data_ok is low, so a pending control sequence goes out ahead of queued FIFO data. A received XOFF does not hold back a control sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rts_auto_en | input | 1 | Enables automatic RTS from the FIFO level |
| cts_auto_en | input | 1 | Enables transmit gating by CTS |
| sw_rx_en | input | 1 | Enables detection and removal of received XON/XOFF |
| sw_tx_en | input | 1 | Enables XON/XOFF requests from the FIFO level |
| two_char_en | input | 1 | Selects two-character sequences |
| rs485_en | input | 1 | RS-485 direction control owns the RTS pin |
| rs485_dir | input | 1 | Driver direction, high while transmitting |
| rx_level | input | LVL_W | Current RX FIFO fill level |
| hi_thresh | input | LVL_W | Level that stops the remote sender |
| lo_thresh | input | LVL_W | Level that restarts the remote sender |
| xon_char1 | input | DATA_W | First resume character |
| xon_char2 | input | DATA_W | Second resume character |
| xoff_char1 | input | DATA_W | First pause character |
| xoff_char2 | input | DATA_W | Second pause character |
| rx_valid | input | 1 | One-clock strobe for a received byte |
| rx_data | input | DATA_W | Received byte |
| rx_push | output | 1 | Write strobe toward the RX FIFO |
| rx_push_data | output | DATA_W | Byte to write into the RX FIFO |
| cts_n | input | 1 | Clear-to-send from the remote side, active low |
| rts_n | output | 1 | Request-to-send, active low |
| tx_ctrl_ack | input | 1 | Transmitter has taken the offered control character |
| tx_ctrl_req | output | 1 | A control character is waiting to be sent |
| tx_ctrl_char | output | DATA_W | Control character to send |
| tx_data_ok | output | 1 | Transmitter may start a new FIFO character |

## Verification
Two functions can meet in one clock: completing a received XOFF pair, and the FIFO level crossing the high threshold, which raises an XOFF request. The bench provokes this by presenting the second pause character and the high FIFO level in the same cycle. It then checks that the request appears with the first pause character and is drained by acknowledges while tx_data_ok stays low. It also checks that data permission returns only after a received XON pair, so the local pause never blocks the outgoing control sequence.

// File: rtl/afc_pkg.sv
package afc_pkg;

   typedef enum logic [1:0] {
      CTL_NONE = 2'd0,
      CTL_STOP = 2'd1,
      CTL_GO   = 2'd2
   } ctl_kind_e;

   function automatic logic ctl_pending(input ctl_kind_e k);
      return k != CTL_NONE;
   endfunction

endpackage

// File: rtl/afc_level_ctrl.sv
module afc_level_ctrl
   import afc_pkg::*;
#(
   parameter int LVL_W  = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [LVL_W-1:0]  hi_thresh,
   input  logic [LVL_W-1:0]  lo_thresh,
   input  logic              rts_auto_en,
   input  logic              rs485_en,
   input  logic              rs485_dir,
   input  logic              sw_tx_en,
   input  logic              two_char_en,
   input  logic [DATA_W-1:0] xon_char1,
   input  logic [DATA_W-1:0] xon_char2,
   input  logic [DATA_W-1:0] xoff_char1,
   input  logic [DATA_W-1:0] xoff_char2,
   input  logic              ctrl_ack,
   output logic              rts_n,
   output logic              ctrl_req,
   output logic [DATA_W-1:0] ctrl_char
);

   logic      full_q;
   logic      set_ev;
   logic      clr_ev;
   ctl_kind_e kind_q;
   logic      second_q;

   // hysteresis: enter the full state at the high mark, leave it at the low mark
   assign set_ev = !full_q && (rx_level >= hi_thresh);
   assign clr_ev =  full_q && (rx_level <= lo_thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      full_q <= 1'b0;
      else if (set_ev) full_q <= 1'b1;
      else if (clr_ev) full_q <= 1'b0;
   end

   // the direction control of a half-duplex driver owns the pin when enabled
   assign rts_n = rs485_en ? !rs485_dir : (rts_auto_en && full_q);

   // control-character request; a new level event replaces any older request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q   <= CTL_NONE;
         second_q <= 1'b0;
      end else if (sw_tx_en && set_ev) begin
         kind_q   <= CTL_STOP;
         second_q <= 1'b0;
      end else if (sw_tx_en && clr_ev) begin
         kind_q   <= CTL_GO;
         second_q <= 1'b0;
      end else if (ctrl_ack && ctl_pending(kind_q)) begin
         if (two_char_en && !second_q) begin
            second_q <= 1'b1;
         end else begin
            kind_q   <= CTL_NONE;
            second_q <= 1'b0;
         end
      end
   end

   assign ctrl_req = ctl_pending(kind_q);

   always_comb begin
      if (kind_q == CTL_STOP) ctrl_char = second_q ? xoff_char2 : xoff_char1;
      else                    ctrl_char = second_q ? xon_char2  : xon_char1;
   end

   AST_FULL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_q) |-> $past(rx_level >= hi_thresh)); // R2
   AST_FULL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(full_q) |-> $past(rx_level <= lo_thresh)); // R2

endmodule

// File: rtl/afc_char_match.sv
module afc_char_match #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rx_en,
   input  logic              two_char_en,
   input  logic [DATA_W-1:0] xon_char1,
   input  logic [DATA_W-1:0] xon_char2,
   input  logic [DATA_W-1:0] xoff_char1,
   input  logic [DATA_W-1:0] xoff_char2,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_push_data,
   output logic              paused
);

   logic              hold_q,   hold_d;
   logic [DATA_W-1:0] hold_b_q, hold_b_d;
   logic              rep_q,    rep_d;
   logic [DATA_W-1:0] rep_b_q,  rep_b_d;
   logic              push_d;
   logic [DATA_W-1:0] push_b_d;
   logic              pause_d;
   logic              in_valid;
   logic [DATA_W-1:0] in_b;

   // a byte replayed after a broken pair is matched again like a fresh one
   assign in_valid = rx_valid || rep_q;
   assign in_b     = rep_q ? rep_b_q : rx_data;

   always_comb begin
      hold_d   = hold_q;
      hold_b_d = hold_b_q;
      rep_d    = 1'b0;
      rep_b_d  = rep_b_q;
      push_d   = 1'b0;
      push_b_d = rx_push_data;
      pause_d  = sw_rx_en && paused;
      if (in_valid) begin
         if (hold_q) begin
            hold_d = 1'b0;
            if (sw_rx_en && two_char_en && hold_b_q == xoff_char1 && in_b == xoff_char2) begin
               pause_d = 1'b1;
            end else if (sw_rx_en && two_char_en && hold_b_q == xon_char1 && in_b == xon_char2) begin
               pause_d = 1'b0;
            end else begin
               push_d   = 1'b1;
               push_b_d = hold_b_q;
               rep_d    = 1'b1;
               rep_b_d  = in_b;
            end
         end else if (sw_rx_en && two_char_en) begin
            if (in_b == xoff_char1 || in_b == xon_char1) begin
               hold_d   = 1'b1;
               hold_b_d = in_b;
            end else begin
               push_d   = 1'b1;
               push_b_d = in_b;
            end
         end else if (sw_rx_en && in_b == xoff_char1) begin
            pause_d = 1'b1;
         end else if (sw_rx_en && in_b == xon_char1) begin
            pause_d = 1'b0;
         end else begin
            push_d   = 1'b1;
            push_b_d = in_b;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q       <= 1'b0;
         hold_b_q     <= '0;
         rep_q        <= 1'b0;
         rep_b_q      <= '0;
         rx_push      <= 1'b0;
         rx_push_data <= '0;
         paused       <= 1'b0;
      end else begin
         hold_q       <= hold_d;
         hold_b_q     <= hold_b_d;
         rep_q        <= rep_d;
         rep_b_q      <= rep_b_d;
         rx_push      <= push_d;
         rx_push_data <= push_b_d;
         paused       <= pause_d;
      end
   end

   AST_PUSH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> ($past(rx_valid) || $past(rep_q))); // R9
   AST_REPLAY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      rep_q |-> !rx_valid); // R8
   AST_PAUSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(paused) |-> ($past(in_valid) && $past(sw_rx_en))); // R6

endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate #(
   parameter int CTS_SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cts_auto_en,
   input  logic cts_n,
   input  logic sw_rx_en,
   input  logic paused,
   input  logic ctrl_req,
   output logic tx_data_ok
);

   logic cts_stop;

   generate
      if (CTS_SYNC == 0) begin : g_direct
         assign cts_stop = cts_n;
      end else if (CTS_SYNC == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= cts_n;
         end
         assign cts_stop = s_q;
      end else begin : g_chain
         logic [CTS_SYNC-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[CTS_SYNC-2:0], cts_n};
         end
         assign cts_stop = s_q[CTS_SYNC-1];
      end
   endgenerate

   // only new starts are gated; a character in the shifter always completes
   assign tx_data_ok = !ctrl_req
                    && !(cts_auto_en && cts_stop)
                    && !(sw_rx_en && paused);

endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow #(
   parameter int DATA_W   = 8,
   parameter int LVL_W    = 7,
   parameter int CTS_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rts_auto_en,
   input  logic              cts_auto_en,
   input  logic              sw_rx_en,
   input  logic              sw_tx_en,
   input  logic              two_char_en,
   input  logic              rs485_en,
   input  logic              rs485_dir,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [LVL_W-1:0]  hi_thresh,
   input  logic [LVL_W-1:0]  lo_thresh,
   input  logic [DATA_W-1:0] xon_char1,
   input  logic [DATA_W-1:0] xon_char2,
   input  logic [DATA_W-1:0] xoff_char1,
   input  logic [DATA_W-1:0] xoff_char2,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_push_data,
   input  logic              cts_n,
   output logic              rts_n,
   input  logic              tx_ctrl_ack,
   output logic              tx_ctrl_req,
   output logic [DATA_W-1:0] tx_ctrl_char,
   output logic              tx_data_ok
);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_data
         $error("uart_autoflow: DATA_W must lie in 5..9");
      end
      if (LVL_W < 2 || LVL_W > 16) begin : g_bad_lvl
         $error("uart_autoflow: LVL_W must lie in 2..16");
      end
      if (CTS_SYNC < 0 || CTS_SYNC > 4) begin : g_bad_sync
         $error("uart_autoflow: CTS_SYNC must lie in 0..4");
      end
   endgenerate

   logic paused;

   afc_level_ctrl #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_level (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_level    (rx_level),
      .hi_thresh   (hi_thresh),
      .lo_thresh   (lo_thresh),
      .rts_auto_en (rts_auto_en),
      .rs485_en    (rs485_en),
      .rs485_dir   (rs485_dir),
      .sw_tx_en    (sw_tx_en),
      .two_char_en (two_char_en),
      .xon_char1   (xon_char1),
      .xon_char2   (xon_char2),
      .xoff_char1  (xoff_char1),
      .xoff_char2  (xoff_char2),
      .ctrl_ack    (tx_ctrl_ack),
      .rts_n       (rts_n),
      .ctrl_req    (tx_ctrl_req),
      .ctrl_char   (tx_ctrl_char)
   );

   afc_char_match #(.DATA_W(DATA_W)) u_match (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_rx_en     (sw_rx_en),
      .two_char_en  (two_char_en),
      .xon_char1    (xon_char1),
      .xon_char2    (xon_char2),
      .xoff_char1   (xoff_char1),
      .xoff_char2   (xoff_char2),
      .rx_valid     (rx_valid),
      .rx_data      (rx_data),
      .rx_push      (rx_push),
      .rx_push_data (rx_push_data),
      .paused       (paused)
   );

   afc_tx_gate #(.CTS_SYNC(CTS_SYNC)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .cts_auto_en (cts_auto_en),
      .cts_n       (cts_n),
      .sw_rx_en    (sw_rx_en),
      .paused      (paused),
      .ctrl_req    (tx_ctrl_req),
      .tx_data_ok  (tx_data_ok)
   );

   AST_CTRL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ctrl_req |-> !tx_data_ok); // R11
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ctrl_req && !tx_ctrl_ack) |=> tx_ctrl_req); // R10

endmodule

// File: tb/uart_autoflow_tb.sv
module uart_autoflow_tb_top;

   localparam int DW = 8;
   localparam int LW = 7;
   localparam logic [DW-1:0] XON1  = 8'h11;
   localparam logic [DW-1:0] XON2  = 8'h12;
   localparam logic [DW-1:0] XOFF1 = 8'h13;
   localparam logic [DW-1:0] XOFF2 = 8'h14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rts_auto_en = 0, cts_auto_en = 0, sw_rx_en = 0, sw_tx_en = 0;
   logic two_char_en = 0, rs485_en = 0, rs485_dir = 0;
   logic [LW-1:0] rx_level = '0;
   logic [LW-1:0] hi_thresh = 7'd48;
   logic [LW-1:0] lo_thresh = 7'd16;
   logic rx_valid = 0;
   logic [DW-1:0] rx_data = '0;
   logic rx_push;
   logic [DW-1:0] rx_push_data;
   logic cts_n = 0;
   logic rts_n;
   logic tx_ctrl_ack = 0;
   logic tx_ctrl_req;
   logic [DW-1:0] tx_ctrl_char;
   logic tx_data_ok;

   int n_checks = 0;
   int n_fail = 0;
   logic [DW-1:0] plog [0:15];
   int plog_n = 0;

   always #5 clk = ~clk;

   uart_autoflow #(.DATA_W(DW), .LVL_W(LW), .CTS_SYNC(2)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .rts_auto_en(rts_auto_en), .cts_auto_en(cts_auto_en),
      .sw_rx_en(sw_rx_en), .sw_tx_en(sw_tx_en), .two_char_en(two_char_en),
      .rs485_en(rs485_en), .rs485_dir(rs485_dir),
      .rx_level(rx_level), .hi_thresh(hi_thresh), .lo_thresh(lo_thresh),
      .xon_char1(XON1), .xon_char2(XON2), .xoff_char1(XOFF1), .xoff_char2(XOFF2),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_push(rx_push), .rx_push_data(rx_push_data),
      .cts_n(cts_n), .rts_n(rts_n),
      .tx_ctrl_ack(tx_ctrl_ack), .tx_ctrl_req(tx_ctrl_req),
      .tx_ctrl_char(tx_ctrl_char), .tx_data_ok(tx_data_ok)
   );

   // forwarded bytes are logged shortly after the edge that registers them
   always @(posedge clk) begin
      #2;
      if (rx_push && plog_n < 16) begin
         plog[plog_n] = rx_push_data;
         plog_n++;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [DW-1:0] b);
      rx_data = b;
      rx_valid = 1'b1;
      tick(1);
      rx_valid = 1'b0;
      tick(3);
   endtask

   task automatic ack_once;
      tx_ctrl_ack = 1'b1;
      tick(1);
      tx_ctrl_ack = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 rts_n", rts_n, 0);
      chk("R1 tx_data_ok", tx_data_ok, 1);
      chk("R1 tx_ctrl_req", tx_ctrl_req, 0);
      chk("R1 rx_push", rx_push, 0);
   endtask

   task automatic t_rts_hyst;
      rts_auto_en = 1;
      rx_level = 7'd47; tick(2);
      chk("R2 below high", rts_n, 0);
      rx_level = 7'd48; tick(1);
      chk("R2 at high after one clock", rts_n, 1);
      rx_level = 7'd30; tick(2);
      chk("R2 between thresholds", rts_n, 1);
      rx_level = 7'd16; tick(1);
      chk("R2 at low after one clock", rts_n, 0);
      rx_level = 7'd0; tick(1);
   endtask

   task automatic t_rts_off_rs485;
      rts_auto_en = 0;
      rx_level = 7'd60; tick(2);
      chk("R3 auto off", rts_n, 0);
      rx_level = 7'd0; tick(2);
      rts_auto_en = 1; rs485_en = 1; rs485_dir = 1;
      rx_level = 7'd60; tick(2);
      chk("R4 dir high overrides full", rts_n, 0);
      rx_level = 7'd0; rs485_dir = 0; tick(2);
      chk("R4 dir low overrides empty", rts_n, 1);
      rs485_en = 0; rts_auto_en = 0; tick(1);
   endtask

   task automatic t_cts;
      cts_auto_en = 1;
      cts_n = 1; tick(1);
      chk("R5 cts still in sync", tx_data_ok, 1);
      tick(1);
      chk("R5 cts stop after sync", tx_data_ok, 0);
      cts_n = 0; tick(2);
      chk("R5 cts resume", tx_data_ok, 1);
      cts_auto_en = 0; cts_n = 1; tick(3);
      chk("R5 cts ignored when off", tx_data_ok, 1);
      cts_n = 0; tick(3);
   endtask

   task automatic t_single;
      sw_rx_en = 1; two_char_en = 0; plog_n = 0;
      send(8'h41);
      chk("R9 data forwarded count", plog_n, 1);
      chk("R9 data forwarded value", plog[0], 8'h41);
      send(XOFF1);
      chk("R6 xoff pauses", tx_data_ok, 0);
      chk("R6 xoff stripped", plog_n, 1);
      send(XON1);
      chk("R6 xon resumes", tx_data_ok, 1);
      chk("R6 xon stripped", plog_n, 1);
   endtask

   task automatic t_two;
      sw_rx_en = 1; two_char_en = 1; plog_n = 0;
      send(XOFF1);
      chk("R7 lone first char no pause", tx_data_ok, 1);
      send(XOFF2);
      chk("R7 pair pauses", tx_data_ok, 0);
      send(XON1);
      chk("R7 lone xon1 no resume", tx_data_ok, 0);
      send(XON2);
      chk("R7 pair resumes", tx_data_ok, 1);
      chk("R7 pairs stripped", plog_n, 0);
   endtask

   task automatic t_partial;
      sw_rx_en = 1; two_char_en = 1; plog_n = 0;
      send(XOFF1);
      send(8'h42);
      chk("R8 broken pair count", plog_n, 2);
      chk("R8 first byte", plog[0], XOFF1);
      chk("R8 second byte", plog[1], 8'h42);
      chk("R8 no pause", tx_data_ok, 1);
      plog_n = 0;
      send(XOFF1);
      send(XOFF1);
      send(XOFF2);
      chk("R8 repeated first char forwarded once", plog_n, 1);
      chk("R8 repeated first char value", plog[0], XOFF1);
      chk("R8 rematch pauses", tx_data_ok, 0);
      send(XON1);
      send(XON2);
      chk("R8 resumed", tx_data_ok, 1);
   endtask

   task automatic t_passthru;
      sw_rx_en = 0; two_char_en = 0; plog_n = 0;
      send(XOFF1);
      chk("R9 disabled forwards", plog_n, 1);
      chk("R9 disabled value", plog[0], XOFF1);
      chk("R9 disabled no pause", tx_data_ok, 1);
   endtask

   task automatic t_ctrl;
      sw_tx_en = 1; two_char_en = 1; sw_rx_en = 0;
      rx_level = 7'd48; tick(1);
      chk("R10 xoff request", tx_ctrl_req, 1);
      chk("R10 xoff first char", tx_ctrl_char, XOFF1);
      chk("R11 data held back", tx_data_ok, 0);
      tick(2);
      chk("R10 char held without ack", tx_ctrl_char, XOFF1);
      ack_once;
      chk("R10 xoff second char", tx_ctrl_char, XOFF2);
      ack_once;
      chk("R10 request done", tx_ctrl_req, 0);
      chk("R11 data released", tx_data_ok, 1);
      rx_level = 7'd16; tick(1);
      chk("R10 xon first char", tx_ctrl_char, XON1);
      ack_once;
      chk("R10 xon second char", tx_ctrl_char, XON2);
      ack_once;
      chk("R10 xon done", tx_ctrl_req, 0);
      two_char_en = 0;
      rx_level = 7'd50; tick(1);
      chk("R10 single xoff char", tx_ctrl_char, XOFF1);
      ack_once;
      chk("R10 single ends after one ack", tx_ctrl_req, 0);
      rx_level = 7'd0; tick(1);
      ack_once;
      sw_tx_en = 0; tick(1);
   endtask

   task automatic t_overlap;
      sw_rx_en = 1; sw_tx_en = 1; two_char_en = 1;
      send(XOFF1);
      rx_data = XOFF2; rx_valid = 1; rx_level = 7'd48;
      tick(1);
      rx_valid = 0;
      chk("R10 overlap request", tx_ctrl_req, 1);
      chk("R10 overlap char", tx_ctrl_char, XOFF1);
      chk("R11 overlap data blocked", tx_data_ok, 0);
      ack_once;
      ack_once;
      chk("R11 control not blocked by pause", tx_ctrl_req, 0);
      chk("R7 still paused", tx_data_ok, 0);
      send(XON1);
      send(XON2);
      chk("R7 overlap resume", tx_data_ok, 1);
      rx_level = 7'd0; tick(1);
      ack_once;
      ack_once;
      chk("R10 xon drained", tx_ctrl_req, 0);
      sw_tx_en = 0; sw_rx_en = 0;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      fork
         begin
            t_reset;
            t_rts_hyst;
            t_rts_off_rs485;
            t_cts;
            t_single;
            t_two;
            t_partial;
            t_passthru;
            t_ctrl;
            t_overlap;
         end
         begin
            repeat (100000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule